// File: doc/BRIEF.md
# Strip Layer Majority Trigger with Triggered Hit Capture

This block sits behind the discriminators of one detector module that has four layers of eight strips. Every clock it removes the strips that configuration has disabled, ORs what remains within each layer, and counts the layers that carry a hit. When that count first reaches a runtime-chosen majority, either two of four or three of four layers, it emits a one-cycle coincidence pulse toward the trigger crate. In the same clock it captures the masked 32-bit strip pattern.

The captured pattern stays pending for a programmable number of cycles. If a local trigger returns from the trigger crate inside that window, the pattern is written into an eight-entry event queue. Readout drains the queue in arrival order. If no local trigger returns in time, the pattern is dropped. A trigger that finds the queue full is lost, and a sticky overflow flag records the loss.

Top module: `strip_majority_trigger`

## Requirements
- R1: Layer L (L = 0..3) is the strip bits [8L+7:8L]. A layer counts as hit in a clock when at least one of its strips is 1 and the matching mask bit is 0.
- R2: With `maj_loose` = 1 the majority condition is at least 2 hit layers. With `maj_loose` = 0 it is at least 3 hit layers. A change of `maj_loose` applies from the next sampling edge.
- R3: `coinc_pulse` is high for exactly the one cycle after the first sampling edge at which the majority condition holds. It stays low while the condition remains true on later edges.
- R4: A strip whose mask bit is 1 adds nothing to any layer hit, and it reads as 0 in every stored pattern.
- R5: The masked strip pattern is captured at the edge that starts a coincidence. A later coincidence replaces a pattern that is still pending.
- R6: With window W (`win_len`, with 0 treated as 1), a `local_trig` sampled 1 to W edges after the capture edge stores the pending pattern. A trigger at a later edge, or when nothing is pending, stores nothing.
- R7: Stored patterns leave in arrival order. `evt_valid` and `evt_data` show the oldest entry from the cycle after it is stored, and `evt_rd` high while `evt_valid` is high removes that entry at the edge.
- R8: `evt_full` is high exactly when the queue holds 8 entries.
- R9: A local trigger that would store a pattern while the queue is full stores nothing and sets `evt_overflow`, which stays set until reset.
- R10: After reset `coinc_pulse`, `evt_valid`, `evt_full` and `evt_overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strip_in | input | 32 | Discriminated strip bits, layer L in bits [8L+7:8L] |
| strip_mask | input | 32 | 1 disables the matching strip |
| maj_loose | input | 1 | 1: two-of-four majority, 0: three-of-four majority |
| win_len | input | 8 | Trigger acceptance window in cycles (0 acts as 1) |
| local_trig | input | 1 | Returned local trigger for this module |
| evt_rd | input | 1 | Removes the head entry of the event queue |
| coinc_pulse | output | 1 | One-cycle coincidence pulse |
| evt_valid | output | 1 | Event queue is not empty |
| evt_data | output | 32 | Masked strip pattern at the queue head |
| evt_full | output | 1 | Event queue holds 8 entries |
| evt_overflow | output | 1 | Sticky flag: a trigger was lost to a full queue |

## Verification
The coincidence pulse is due one cycle after the edge that samples the majority strips. A stored pattern appears at the queue head one cycle after the edge that samples the accepted trigger. A pop shows its effect one cycle after the sampling edge. The bench drives every input at a falling edge and checks outputs at the following falling edge, half a cycle after the rising edge in question. Triggers are placed at exact edge offsets from the capture edge, so that the first and last cycles of the window and the first cycle after it are each tested. A queue in the bench holds the expected patterns, and the readout task compares the head against that queue on every pop.

// File: rtl/lmc_pkg.sv
`timescale 1ns/1ps
package lmc_pkg;

  // Layers needed for a coincidence: half of them in loose mode, all but one otherwise.
  function automatic int unsigned hit_threshold(input logic loose, input int unsigned layers);
    return loose ? (layers / 2) : (layers - 1);
  endfunction

  // A zero window still grants one cycle.
  function automatic int unsigned window_cycles(input int unsigned win);
    return (win == 0) ? 1 : win;
  endfunction

endpackage

// File: rtl/lmc_layer_or.sv
`timescale 1ns/1ps
module lmc_layer_or #(
  parameter int LAYERS = 4,
  parameter int STRIPS = 8,
  localparam int NCH = LAYERS * STRIPS
) (
  input  logic [NCH-1:0]    strips,
  input  logic [NCH-1:0]    mask,
  output logic [NCH-1:0]    masked,
  output logic [LAYERS-1:0] layer_hit
);

  for (genvar l = 0; l < LAYERS; l++) begin : g_layer
    assign masked[l*STRIPS +: STRIPS] = strips[l*STRIPS +: STRIPS] & ~mask[l*STRIPS +: STRIPS];
    assign layer_hit[l]               = |masked[l*STRIPS +: STRIPS];
  end

endmodule

// File: rtl/lmc_majority.sv
`timescale 1ns/1ps
module lmc_majority #(
  parameter int LAYERS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAYERS-1:0] layer_hit,
  input  logic              loose,
  output logic              maj_now,
  output logic              maj_rise,
  output logic              pulse
);
  import lmc_pkg::*;

  function automatic int unsigned count_hits(input logic [LAYERS-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < LAYERS; i++) n += v[i] ? 1 : 0;
    return n;
  endfunction

  logic maj_q;

  assign maj_now  = count_hits(layer_hit) >= hit_threshold(loose, LAYERS);
  assign maj_rise = maj_now & ~maj_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maj_q <= 1'b0;
      pulse <= 1'b0;
    end else begin
      maj_q <= maj_now;
      pulse <= maj_rise;
    end
  end

  // R3: a pulse never lasts more than one cycle
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  // R2: a pulse follows an edge where the majority held
  assert_pulse_has_majority_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(maj_now));

endmodule

// File: rtl/lmc_hold.sv
`timescale 1ns/1ps
module lmc_hold #(
  parameter int WIDTH = 32,
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [WIDTH-1:0] pat_in,
  input  logic             trig,
  input  logic [WIN_W-1:0] win_len,
  input  logic             q_full,
  output logic             push,
  output logic [WIDTH-1:0] push_data,
  output logic             pending,
  output logic             overflow
);
  import lmc_pkg::*;

  logic [WIDTH-1:0] pat_q;
  logic [WIN_W-1:0] timer_q;
  logic             take;
  logic             last_cycle;

  assign take       = pending & trig;
  assign last_cycle = (timer_q <= WIN_W'(1));
  assign push       = take & ~q_full;
  assign push_data  = pat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      timer_q  <= '0;
      pat_q    <= '0;
      overflow <= 1'b0;
    end else begin
      if (take && q_full) overflow <= 1'b1;
      if (capture) begin
        pending <= 1'b1;
        pat_q   <= pat_in;
        timer_q <= WIN_W'(window_cycles(int'(win_len)));
      end else if (pending && (trig || last_cycle)) begin
        pending <= 1'b0;
      end else if (pending) begin
        timer_q <= timer_q - 1'b1;
      end
    end
  end

  // R6: the window closes after its last cycle with no trigger and no new capture
  assert_window_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !trig && !capture && last_cycle) |=> !pending);

  // R9: the overflow flag is sticky
  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R5: a capture always leaves a pattern pending
  assert_capture_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> pending);

endmodule

// File: rtl/lmc_evt_fifo.sv
`timescale 1ns/1ps
module lmc_evt_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  output logic             valid,
  output logic [WIDTH-1:0] head,
  output logic             full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign valid   = (cnt != '0);
  assign full    = (cnt == CW'(DEPTH));
  assign head    = mem[rd_ptr];
  assign do_push = push & ~full;
  assign do_pop  = rd & valid;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R9: the holder never offers a pattern into a full queue
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  // R8: a full queue stays full until it is read
  assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd) |=> full);

  // R7: occupancy never exceeds the depth
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

endmodule

// File: rtl/strip_majority_trigger.sv
`timescale 1ns/1ps
module strip_majority_trigger #(
  parameter int LAYERS = 4,
  parameter int STRIPS = 8,
  parameter int DEPTH  = 8,
  parameter int WIN_W  = 8,
  localparam int NCH   = LAYERS * STRIPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   strip_in,
  input  logic [NCH-1:0]   strip_mask,
  input  logic             maj_loose,
  input  logic [WIN_W-1:0] win_len,
  input  logic             local_trig,
  input  logic             evt_rd,
  output logic             coinc_pulse,
  output logic             evt_valid,
  output logic [NCH-1:0]   evt_data,
  output logic             evt_full,
  output logic             evt_overflow
);

  logic [NCH-1:0]    masked_pat;
  logic [LAYERS-1:0] layer_hit;
  logic              maj_now, maj_rise;
  logic              q_push, pending;
  logic [NCH-1:0]    q_wdata;

  lmc_layer_or #(.LAYERS(LAYERS), .STRIPS(STRIPS)) u_layers (
    .strips(strip_in), .mask(strip_mask), .masked(masked_pat), .layer_hit(layer_hit)
  );

  lmc_majority #(.LAYERS(LAYERS)) u_maj (
    .clk(clk), .rst_n(rst_n), .layer_hit(layer_hit), .loose(maj_loose),
    .maj_now(maj_now), .maj_rise(maj_rise), .pulse(coinc_pulse)
  );

  lmc_hold #(.WIDTH(NCH), .WIN_W(WIN_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .capture(maj_rise), .pat_in(masked_pat),
    .trig(local_trig), .win_len(win_len), .q_full(evt_full),
    .push(q_push), .push_data(q_wdata), .pending(pending), .overflow(evt_overflow)
  );

  lmc_evt_fifo #(.WIDTH(NCH), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(q_push), .wdata(q_wdata), .rd(evt_rd),
    .valid(evt_valid), .head(evt_data), .full(evt_full)
  );

  // R6: no trigger stores anything while no pattern is pending
  assert_trig_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !evt_valid && !evt_rd) |=> !evt_valid);

  // R3: a steady majority gives no new pulse
  assert_no_retrigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(maj_now) && maj_now) |=> !coinc_pulse);

endmodule

// File: tb/sim_strip_majority_trigger.sv
`timescale 1ns/1ps
module sim_strip_majority_trigger;
  localparam int L = 4, S = 8, N = 32, D = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, maj_loose, local_trig, evt_rd;
  logic [N-1:0] strip_in, strip_mask, evt_data;
  logic [7:0] win_len;
  logic coinc_pulse, evt_valid, evt_full, evt_overflow;

  strip_majority_trigger u0 (
    .clk(clk), .rst_n(rst_n), .strip_in(strip_in), .strip_mask(strip_mask),
    .maj_loose(maj_loose), .win_len(win_len), .local_trig(local_trig), .evt_rd(evt_rd),
    .coinc_pulse(coinc_pulse), .evt_valid(evt_valid), .evt_data(evt_data),
    .evt_full(evt_full), .evt_overflow(evt_overflow)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  bit exp_ovf = 0;
  logic [N-1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // independent model: count layers that own an unmasked high strip
  function automatic bit model_major(input logic [N-1:0] s, input logic [N-1:0] m, input bit loose);
    int hits = 0;
    for (int l = 0; l < L; l++) begin
      bit any = 0;
      for (int k = 0; k < S; k++) if (s[l*S+k] && !m[l*S+k]) any = 1;
      if (any) hits++;
    end
    return loose ? (hits >= 2) : (hits >= 3);
  endfunction

  // driver: coincidence then a trigger d edges after the capture edge
  task automatic fire(input logic [N-1:0] pat, input int d, input string req);
    strip_in = pat;
    tick();
    strip_in = '0;
    chk(coinc_pulse == 1'b1, "R3", "pulse for event", coinc_pulse, 1);
    repeat (d - 1) tick();
    local_trig = 1'b1;
    tick();
    local_trig = 1'b0;
    if (d <= ((win_len == 0) ? 1 : int'(win_len))) begin
      if (exp_q.size() < D) exp_q.push_back(pat & ~strip_mask);
      else exp_ovf = 1;
    end
    chk(evt_valid == (exp_q.size() > 0), req, "valid after trigger", evt_valid, exp_q.size() > 0);
    chk(evt_full == (exp_q.size() == D), "R8", "full flag", evt_full, exp_q.size() == D);
    chk(evt_overflow == exp_ovf, "R9", "overflow flag", evt_overflow, exp_ovf);
  endtask

  // monitor: pop the design queue and compare with the scoreboard
  task automatic drain();
    while (exp_q.size() > 0) begin
      logic [N-1:0] e;
      e = exp_q.pop_front();
      chk(evt_valid == 1'b1, "R7", "valid during readout", evt_valid, 1);
      chk(evt_data == e, "R7", "readout order/data", evt_data, e);
      evt_rd = 1'b1;
      tick();
      evt_rd = 1'b0;
    end
    chk(evt_valid == 1'b0, "R7", "empty after readout", evt_valid, 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; strip_in = '0; strip_mask = '0; maj_loose = 1; win_len = 8'd4;
    local_trig = 0; evt_rd = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R10 reset state
    chk(coinc_pulse == 0, "R10", "pulse after reset", coinc_pulse, 0);
    chk(evt_valid == 0, "R10", "valid after reset", evt_valid, 0);
    chk(evt_full == 0, "R10", "full after reset", evt_full, 0);
    chk(evt_overflow == 0, "R10", "overflow after reset", evt_overflow, 0);

    // R2/R1 loose mode: two layers -> pulse, then held high -> no repeat (R3)
    strip_in = 32'h0000_0101;
    tick();
    chk(coinc_pulse == model_major(strip_in, strip_mask, 1), "R2", "two layers loose", coinc_pulse, 1);
    tick();
    chk(coinc_pulse == 0, "R3", "no retrigger while held", coinc_pulse, 0);
    strip_in = '0; tick();
    // one layer only (R1): no pulse
    strip_in = 32'h0000_00F0; tick();
    chk(coinc_pulse == model_major(strip_in, strip_mask, 1), "R1", "single layer", coinc_pulse, 0);
    strip_in = '0; tick();
    // strict mode: two layers insufficient, three fire
    maj_loose = 0;
    strip_in = 32'h8000_0001; tick();
    chk(coinc_pulse == model_major(strip_in, strip_mask, 0), "R2", "two layers strict", coinc_pulse, 0);
    strip_in = '0; tick();
    strip_in = 32'h0080_4001; tick();
    chk(coinc_pulse == model_major(strip_in, strip_mask, 0), "R2", "three layers strict", coinc_pulse, 1);
    strip_in = '0; tick();
    // R4: hits only on masked strips do not count
    strip_mask = 32'h00FF_FFFF;
    strip_in = 32'h0011_2233; tick();
    chk(coinc_pulse == model_major(strip_in, strip_mask, 0), "R4", "masked strips", coinc_pulse, 0);
    strip_in = '0; strip_mask = '0;
    repeat (10) tick();

    // R6: trigger with nothing pending is ignored
    local_trig = 1; tick(); local_trig = 0; tick();
    chk(evt_valid == 0, "R6", "idle trigger ignored", evt_valid, 0);

    // R6 window edges with W=4, masked bits cleared in the stored pattern (R4)
    maj_loose = 1;
    strip_mask = 32'h0000_0003;
    fire(32'h0001_0103, 1, "R6");
    fire(32'h0200_0200, 4, "R6");
    fire(32'h0400_0004, 5, "R6");
    strip_mask = '0;
    drain();

    // R5: a second coincidence replaces the pending pattern
    strip_in = 32'h0000_0303; tick();
    strip_in = '0; tick();
    strip_in = 32'h0C0C_0000; tick();
    strip_in = '0; local_trig = 1; tick(); local_trig = 0;
    exp_q.push_back(32'h0C0C_0000);
    chk(evt_valid == 1, "R5", "replaced pattern stored", evt_valid, 1);
    drain();

    // R8/R9: fill the queue then overflow
    for (int i = 0; i < D; i++) fire(32'h0101_0000 | (i + 1), 2, "R7");
    fire(32'hFFFF_FFFF, 1, "R9");
    drain();
    chk(evt_overflow == 1, "R9", "overflow sticky after drain", evt_overflow, 1);
    chk(evt_full == 0, "R8", "not full after drain", evt_full, 0);

    summary();
  end
endmodule